// File: doc/BRIEF.md
# GPIO Command Executor for a Coprocessor Port

This block carries out GPIO commands that a processor sends over a coprocessor port. It owns 64 output levels and 64 output enables, each stored as two 32-bit halves. It also registers 64 input pins. A command carries these fields:
- an opcode,
- a register selector,
- a flag that tells a one-operand command from a two-operand command,
- two 32-bit operands.

The commands cover several kinds of update. Whole-half mask updates replace, toggle, set or clear bits. Paired updates change both halves on the same edge. Single-bit updates name a pin number and may carry a condition bit. Indexed updates pick the half at run time. A combinational read port returns any half of the stored state, or the sampled inputs.

Commands come as a one-cycle `cmd_valid` strobe. The block accepts a command on every cycle and never applies back-pressure, so there is no ready signal. A command that is not accepted on the edge where it is presented is lost, and the issuer must not hold `cmd_valid` expecting a retry.

Top module: `gpio_cmd_exec`

## Requirements
- R1: After reset, `pad_out` and `pad_oe` are all zero: every output is low and every pin is an input.
- R2: A one-operand command (`cmd_pair`=0) with opcode 0, 1, 2 or 3 does the following to the register picked by `cmd_sel`, using `cmd_op0`. Opcode 0 replaces the register, 1 XORs into it, 2 ORs into it and 3 clears the bits that are 1 in the operand. The selector values are: 0 is output bits 31:0, 1 is output bits 63:32, 4 is enable bits 31:0 and 5 is enable bits 63:32.
- R3: A two-operand command with opcode 0 to 3 and `cmd_sel` 0 (output) or 4 (enable) applies the operation to bits 31:0 from `cmd_op0` and to bits 63:32 from `cmd_op1`. Both halves change on the same edge. A two-operand command of this kind with selector 1 or 5 changes nothing.
- R4: A two-operand command with opcode 4 and selector 0 or 4 writes `cmd_op1[0]` into the bit numbered `cmd_op0[5:0]` of the selected register.
- R5: A one-operand command with opcode 5, 6 or 7 and selector 0 or 4 toggles, sets or clears (in that order) the bit numbered `cmd_op0[5:0]`.
- R6: The same opcodes as two-operand commands act only when `cmd_op1[0]` is 1. When it is 0, both registers stay unchanged.
- R7: A two-operand command with opcode 8, 9, 10 or 11 and selector 0 or 4 applies replace, XOR, OR or clear (in that order) with data `cmd_op0`. The target half comes from the index `cmd_op1`: index 0 means bits 31:0 and index 1 means bits 63:32. Any other index changes nothing.
- R8: `rd_lo` returns the half named by `rd_sel` (0, 1, 4 or 5 as in R2, 8 for input bits 31:0, 9 for input bits 63:32). `rd_hi` returns the upper half of the same kind. Any other selector reads as zero on both.
- R9: The inputs are registered as one 64-bit word on every edge. The value of `pins_in` at an edge is what a read returns after that edge.
- R10: A command takes effect at the edge where `cmd_valid` is 1. Some commands change nothing: cycles without `cmd_valid`, opcodes 12 to 15, one-operand opcodes 4 and 8 to 11, and selectors other than 0, 1, 4 and 5.
- R11: Pin numbers use only bits 5:0 of the operand, so pin 104 addresses pin 40. Bit 5 of the pin number picks the upper half, and a single-bit command changes at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_pair | input | 1 | 1 for a two-operand command |
| cmd_opc | input | 4 | Opcode |
| cmd_sel | input | 4 | Register selector |
| cmd_op0 | input | 32 | First operand |
| cmd_op1 | input | 32 | Second operand |
| pins_in | input | 64 | Raw input pins |
| rd_sel | input | 4 | Read selector |
| rd_lo | output | 32 | Read result, selected half |
| rd_hi | output | 32 | Read result, upper half of same kind |
| pad_out | output | 64 | Output levels |
| pad_oe | output | 64 | Output enables |

## Verification
There are two cases where functions share a cycle.

First, a paired write and the input sampler can act on the same edge. The bench presents a two-operand output write while changing `pins_in`. After that edge it judges both halves of `pad_out` and the paired input read together.

Second, both halves of one register can change in a single command. The bench's sweep runs every opcode, selector and operand-count combination, and compares the full 64-bit state with an arithmetic model after each command. A half that updated one cycle late shows up as a mismatch.

// File: rtl/gpio_cmd_pkg.sv
package gpio_cmd_pkg;
  parameter int HALF_W = 32;
  localparam int PINS = 2 * HALF_W;
  localparam int PIN_BITS = $clog2(PINS);

  typedef enum logic [1:0] {
    BOP_PUT = 2'd0,
    BOP_XOR = 2'd1,
    BOP_SET = 2'd2,
    BOP_CLR = 2'd3
  } bitop_e;

  typedef struct packed {
    logic            hit_out;
    logic            hit_oe;
    logic [1:0]      half_we;
    bitop_e          op;
    logic [PINS-1:0] data;
  } bank_upd_t;
endpackage

// File: rtl/gpio_cmd_decode.sv
module gpio_cmd_decode
  import gpio_cmd_pkg::*;
(
  input  logic              valid,
  input  logic              pair,
  input  logic [3:0]        opc,
  input  logic [3:0]        sel,
  input  logic [HALF_W-1:0] op0,
  input  logic [HALF_W-1:0] op1,
  output bank_upd_t         upd
);
  logic                sel_ok;
  logic                sel_hi;
  logic [PINS-1:0]     pin_mask;
  logic                go;

  assign sel_ok   = (sel[3] == 1'b0) && (sel[1] == 1'b0);
  assign sel_hi   = sel[0];
  assign pin_mask = {{(PINS-1){1'b0}}, 1'b1} << op0[PIN_BITS-1:0];

  always_comb begin
    go           = 1'b0;
    upd.op       = BOP_PUT;
    upd.half_we  = 2'b00;
    upd.data     = '0;
    if (valid && sel_ok) begin
      if (opc[3:2] == 2'b00) begin
        upd.op = bitop_e'(opc[1:0]);
        if (!pair) begin
          go          = 1'b1;
          upd.half_we = sel_hi ? 2'b10 : 2'b01;
          upd.data    = {op0, op0};
        end else if (!sel_hi) begin
          go          = 1'b1;
          upd.half_we = 2'b11;
          upd.data    = {op1, op0};
        end
      end else if (opc == 4'd4) begin
        if (pair && !sel_hi) begin
          go          = 1'b1;
          upd.op      = op1[0] ? BOP_SET : BOP_CLR;
          upd.half_we = 2'b11;
          upd.data    = pin_mask;
        end
      end else if (opc[3:2] == 2'b01) begin
        if (!sel_hi && (!pair || op1[0])) begin
          go          = 1'b1;
          upd.op      = bitop_e'(opc[1:0]);
          upd.half_we = 2'b11;
          upd.data    = pin_mask;
        end
      end else if (opc[3:2] == 2'b10) begin
        if (pair && !sel_hi && (op1[HALF_W-1:1] == '0)) begin
          go          = 1'b1;
          upd.op      = bitop_e'(opc[1:0]);
          upd.half_we = op1[0] ? 2'b10 : 2'b01;
          upd.data    = {op0, op0};
        end
      end
    end
    upd.hit_out = go && !sel[2];
    upd.hit_oe  = go && sel[2];
  end
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [1:0]      half_we,
  input  bitop_e          op,
  input  logic [PINS-1:0] data,
  output logic [PINS-1:0] q
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] cur;
    logic [HALF_W-1:0] din;
    logic [HALF_W-1:0] nxt;
    assign cur = q[h*HALF_W +: HALF_W];
    assign din = data[h*HALF_W +: HALF_W];

    always_comb begin
      case (op)
        BOP_PUT: nxt = din;
        BOP_XOR: nxt = cur ^ din;
        BOP_SET: nxt = cur | din;
        default: nxt = cur & ~din;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[h*HALF_W +: HALF_W] <= '0;
      else if (hit && half_we[h])
        q[h*HALF_W +: HALF_W] <= nxt;
    end
  end
endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample
  import gpio_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pins,
  output logic [PINS-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= pins;
  end
endmodule

// File: rtl/gpio_cmd_exec.sv
module gpio_cmd_exec
  import gpio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_pair,
  input  logic [3:0]        cmd_opc,
  input  logic [3:0]        cmd_sel,
  input  logic [HALF_W-1:0] cmd_op0,
  input  logic [HALF_W-1:0] cmd_op1,
  input  logic [PINS-1:0]   pins_in,
  input  logic [3:0]        rd_sel,
  output logic [HALF_W-1:0] rd_lo,
  output logic [HALF_W-1:0] rd_hi,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  bank_upd_t       upd;
  logic [PINS-1:0] in_q;
  logic [PINS-1:0] rd_word;
  logic            rd_ok;

  gpio_cmd_decode u_dec (
    .valid (cmd_valid),
    .pair  (cmd_pair),
    .opc   (cmd_opc),
    .sel   (cmd_sel),
    .op0   (cmd_op0),
    .op1   (cmd_op1),
    .upd   (upd)
  );

  gpio_reg_bank u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (upd.hit_out),
    .half_we (upd.half_we),
    .op      (upd.op),
    .data    (upd.data),
    .q       (pad_out)
  );

  gpio_reg_bank u_oe (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (upd.hit_oe),
    .half_we (upd.half_we),
    .op      (upd.op),
    .data    (upd.data),
    .q       (pad_oe)
  );

  gpio_in_sample u_in (
    .clk   (clk),
    .rst_n (rst_n),
    .pins  (pins_in),
    .q     (in_q)
  );

  always_comb begin
    rd_ok   = 1'b1;
    case (rd_sel[3:1])
      3'b000:  rd_word = pad_out;
      3'b010:  rd_word = pad_oe;
      3'b100:  rd_word = in_q;
      default: begin rd_word = '0; rd_ok = 1'b0; end
    endcase
    rd_hi = rd_word[PINS-1:HALF_W];
    rd_lo = (rd_ok && rd_sel[0]) ? rd_word[PINS-1:HALF_W] : rd_word[HALF_W-1:0];
  end
endmodule

// File: rtl/gpio_cmd_exec_chk.sv
module gpio_cmd_exec_chk
  import gpio_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_pair,
  input logic [3:0]        cmd_opc,
  input logic [3:0]        cmd_sel,
  input logic [HALF_W-1:0] cmd_op0,
  input logic [HALF_W-1:0] cmd_op1,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe
);
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(pad_out) && $stable(pad_oe)));

  assert_out_sel_spares_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_sel[3:1] == 3'b000) |=> $stable(pad_oe));

  assert_single_bit_one_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_sel == 4'd0 && (cmd_opc == 4'd4 || cmd_opc[3:2] == 2'b01))
      |=> ($countones(pad_out ^ $past(pad_out)) <= 1));

  assert_cond_zero_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_pair && cmd_opc[3:2] == 2'b01 && cmd_opc[1:0] != 2'b00 && !cmd_op1[0])
      |=> ($stable(pad_out) && $stable(pad_oe)));

  assert_bad_index_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opc[3:2] == 2'b10 && cmd_op1 > 32'd1)
      |=> ($stable(pad_out) && $stable(pad_oe)));

  assert_set_never_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opc == 4'd2 && cmd_sel[3:1] == 3'b000)
      |=> (($past(pad_out) & ~pad_out) == '0));
endmodule

bind gpio_cmd_exec gpio_cmd_exec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_pair  (cmd_pair),
  .cmd_opc   (cmd_opc),
  .cmd_sel   (cmd_sel),
  .cmd_op0   (cmd_op0),
  .cmd_op1   (cmd_op1),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/test_gpio_cmd_exec.sv
module test_gpio_cmd_exec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_pair = 1'b0;
  logic [3:0]  cmd_opc = '0;
  logic [3:0]  cmd_sel = '0;
  logic [31:0] cmd_op0 = '0;
  logic [31:0] cmd_op1 = '0;
  logic [63:0] pins_in = '0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_lo, rd_hi;
  logic [63:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] m_out = '0;
  logic [63:0] m_oe = '0;
  logic [63:0] m_in = '0;
  logic [31:0] seed = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_cmd_exec i_gpio_cmd_exec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pair(cmd_pair),
    .cmd_opc(cmd_opc), .cmd_sel(cmd_sel), .cmd_op0(cmd_op0), .cmd_op1(cmd_op1),
    .pins_in(pins_in), .rd_sel(rd_sel), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [63:0] apply(int kind, logic [63:0] cur, logic [63:0] d, logic [63:0] wm);
    case (kind)
      0: return (cur & ~wm) | (d & wm);
      1: return cur ^ (d & wm);
      2: return cur | (d & wm);
      default: return cur & ~(d & wm);
    endcase
  endfunction

  // Reference model from the requirements
  task automatic model(bit pair, int opc, int sel, logic [31:0] a, logic [31:0] b);
    logic [63:0] cur, bit1, lo_m, hi_m;
    bit hi, is_oe;
    lo_m = 64'h0000_0000_FFFF_FFFF;
    hi_m = ~lo_m;
    if (!(sel == 0 || sel == 1 || sel == 4 || sel == 5)) return; // R10
    is_oe = (sel >= 4);
    hi = (sel % 2) == 1;
    cur = is_oe ? m_oe : m_out;
    bit1 = 64'd1 << (a % 64); // R11 modulo 64
    if (opc < 4 && !pair)
      cur = apply(opc, cur, {a, a}, hi ? hi_m : lo_m);
    else if (opc < 4 && pair && !hi)
      cur = apply(opc, cur, {b, a}, ~64'd0);
    else if (opc == 4 && pair && !hi)
      cur = b[0] ? (cur | bit1) : (cur & ~bit1);
    else if (opc >= 5 && opc <= 7 && !hi && (!pair || b[0]))
      cur = apply(opc - 4, cur, bit1, ~64'd0);
    else if (opc >= 8 && opc <= 11 && pair && !hi && b < 2)
      cur = apply(opc - 8, cur, {a, a}, (b == 1) ? hi_m : lo_m);
    if (is_oe) m_oe = cur; else m_out = cur;
  endtask

  function automatic string tag(bit pair, int opc, int sel);
    if (!(sel == 0 || sel == 1 || sel == 4 || sel == 5)) return "R10";
    if (opc < 4) return pair ? "R3" : "R2";
    if (opc == 4) return pair ? "R4" : "R10";
    if (opc <= 7) return pair ? "R6" : "R5";
    if (opc <= 11) return pair ? "R7" : "R10";
    return "R10";
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(bit pair, int opc, int sel, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pair = pair; cmd_opc = 4'(opc); cmd_sel = 4'(sel);
    cmd_op0 = a; cmd_op1 = b;
    @(posedge clk);
    model(pair, opc, sel, a, b);
    @(negedge clk);
    cmd_valid = 1'b0;
    check64({tag(pair, opc, sel), " out"}, pad_out, m_out);
    check64({tag(pair, opc, sel), " oe"}, pad_oe, m_oe);
  endtask

  task automatic check_reads(string req);
    for (int s = 0; s < 16; s++) begin
      logic [63:0] w;
      rd_sel = 4'(s);
      #1;
      case (s)
        0, 1: w = m_out;
        4, 5: w = m_oe;
        8, 9: w = m_in;
        default: w = '0;
      endcase
      check64(req, {rd_hi, rd_lo}, {w[63:32], (s % 2 == 1) ? w[63:32] : w[31:0]});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check64("R1 out", pad_out, 64'd0);
    check64("R1 oe", pad_oe, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R1 out after release", pad_out, 64'd0);

    // R2/R3 fill state, then near-exhaustive sweep
    issue(1, 0, 0, 32'hA5A5_0F0F, 32'h1234_8001);
    issue(1, 0, 4, 32'h00FF_00FF, 32'hF00F_0FF0);
    for (int r = 0; r < 6; r++)
      for (int opc = 0; opc < 16; opc++)
        for (int sel = 0; sel < 16; sel++)
          for (int p = 0; p < 2; p++) begin
            logic [31:0] a, b;
            a = rnd();
            b = rnd();
            if (opc >= 8 && r < 3) b = 32'(r); // R7 indices 0, 1, 2
            issue(p[0], opc, sel, a, b);
          end

    // R10 idle cycles change nothing
    cmd_opc = 4'd0; cmd_sel = 4'd0; cmd_op0 = 32'hFFFF_FFFF; cmd_pair = 1'b0;
    repeat (3) @(negedge clk);
    check64("R10 idle out", pad_out, m_out);
    check64("R10 idle oe", pad_oe, m_oe);

    // R11 pin 104 addresses pin 40 (upper half)
    issue(0, 7, 0, 32'd40, 32'd0);
    issue(0, 6, 0, 32'd104, 32'd0);
    checks++;
    if (pad_out[40] !== 1'b1) begin
      errors++;
      $display("FAIL R11 pin40 actual=%b expected=1", pad_out[40]);
    end

    // R8/R9 paired write and input sample in the same cycle
    @(negedge clk);
    pins_in = 64'hDEAD_BEEF_0123_4567;
    cmd_valid = 1'b1; cmd_pair = 1'b1; cmd_opc = 4'd0; cmd_sel = 4'd0;
    cmd_op0 = 32'h5555_AAAA; cmd_op1 = 32'h0F0F_F0F0;
    @(posedge clk);
    model(1, 0, 0, 32'h5555_AAAA, 32'h0F0F_F0F0);
    m_in = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    cmd_valid = 1'b0;
    check64("R3 same-edge out", pad_out, m_out);
    check_reads("R8 R9 read");
    pins_in = 64'h8000_0001_7FFF_FFFE;
    @(negedge clk);
    m_in = 64'h8000_0001_7FFF_FFFE;
    check_reads("R9 resample");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule